// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Write-Control Emulator

This block is a clocked, synthesizable stand-in for the control logic of a 2048 x 8 byte-alterable nonvolatile memory. It is driven from pin-level signals: active-low chip select, read strobe and write strobe, an 11-bit address and an 8-bit data bus. The data bus is split into an input, an output and an output-drive flag. A low drive flag stands for a released, high-impedance bus. All strobes, the address and the data are brought into the system clock domain through two flip-flops. Edges are detected by comparing each synchronized sample with the sample taken one cycle earlier.

A write strobe latches its address when the strobe opens and its data when the strobe closes. Strobes that are too short are discarded. Accepted bytes fill a 16-byte page buffer. A byte-load window timer decides when loading stops. A programming timer then models the busy period, and at its end every loaded byte is copied into a register array in one step. While programming runs, a read of the most recently loaded address returns that byte with its top bit inverted. Software can poll this bit to see when the write has finished.

Top module: `eepr_ctrl_emu`

## Requirements
- R1: A read is active while `ce_n` and `oe_n` are both 0 and `we_n` is 1. During a read, `data_oe` is 1 and `data_out` shows the word at `addr`. In every other case `data_oe` is 0 and `data_out` is 0. Pin changes reach the outputs two clock cycles later.
- R2: A byte load happens only while `ce_n` and `we_n` are both 0 and `oe_n` is 1. Holding `oe_n` at 0 through such a strobe loads nothing.
- R3: The load address is the one present when the later of `ce_n` and `we_n` falls. The load data is the value present in the last cycle before the earlier of the two rises.
- R4: A page is 16 bytes. It is selected by `addr[10:4]`, and `addr[3:0]` picks the byte inside the page. All bytes loaded into one page are programmed together. If the same byte is loaded twice, the later value is the one programmed.
- R5: Each load must begin within `LOAD_WIN_CYC` cycles of the start of the previous strobe. Once that window passes with no new strobe, programming of the buffered bytes starts.
- R6: Programming lasts `PROG_CYC` cycles and runs with no further host action. The array shows the new bytes only after it ends.
- R7: During programming, a read of the last loaded address returns that byte with bit 7 inverted and bits 6..0 unchanged. After programming, the same read returns the true byte.
- R8: A write strobe that stays active for fewer than `MIN_LOW_CYC` synchronized cycles loads nothing.
- R9: While a page is open, a load whose `addr[10:4]` differs from the open page is ignored, and the open page is kept.
- R10: Loads attempted during programming are ignored. During programming, a read of any address other than the last loaded one returns the array contents.
- R11: Bytes of a page that were not loaded keep their previous array values. After reset, every array byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 11 | Word address; bits 10..4 select the page |
| data_in | input | 8 | Data driven by the host during writes |
| data_out | output | 8 | Read data, 0 when the bus is released |
| data_oe | output | 1 | 1 while the block drives the bus |

## Verification
Random pages are filled with 1 to 16 bytes at random offsets, sometimes repeating an offset. Stray loads to a foreign page are sometimes slipped in. Every byte of each page is then compared with a bench model. This separates correct page merging from loss of unloaded bytes and from foreign bytes leaking in.

Directed cases each single out one rule:
- A write controlled by chip select, with the address and data moved in mid-strobe, shows which edge latches each of them.
- A one-cycle glitch and a strobe held with the read strobe low show which pulses are rejected.
- A load placed after the window has closed is checked against one placed inside it.
- Reads of the polled address and of a neighbouring address during programming separate the inverted-bit status from plain array reads.

// File: rtl/eepr_pkg.sv
package eepr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } ph_e;
endpackage

// File: rtl/eepr_sync.sv
module eepr_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = din;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1 <= INIT;
            q.s2 <= INIT;
        end else begin
            q <= d;
        end
    end

    assign dout = q.s2;
endmodule

// File: rtl/eepr_cycle.sv
module eepr_cycle #(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int MIN_LOW_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              oe_s,
    input  logic              we_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              rd_act,
    output logic              wr_act,
    output logic              ld_start,
    output logic              ld_valid,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data
);
    localparam int LC_W = $clog2(MIN_LOW_CYC + 1);

    typedef struct packed {
        logic              wr;
        logic [LC_W-1:0]   low;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] dat;
    } cyc_t;

    cyc_t q, d;

    assign wr_act = ~ce_s & ~we_s & oe_s;
    assign rd_act = ~ce_s & ~oe_s & we_s;

    always_comb begin
        d        = q;
        d.wr     = wr_act;
        ld_start = wr_act & ~q.wr;
        if (ld_start) begin
            d.a   = addr_s;
            d.low = LC_W'(1);
        end else if (wr_act && (q.low < LC_W'(MIN_LOW_CYC))) begin
            d.low = q.low + LC_W'(1);
        end
        if (wr_act) begin
            d.dat = data_s;
        end
        ld_valid = q.wr & ~wr_act & (q.low >= LC_W'(MIN_LOW_CYC));
        ld_addr  = q.a;
        ld_data  = q.dat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R2: one strobe yields at most a single-cycle load pulse
    assert_single_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid);

    // R3: latched address does not move once a strobe is open
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr && wr_act) |=> $stable(q.a));
endmodule

// File: rtl/eepr_page.sv
module eepr_page #(
    parameter int OFS_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [OFS_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             clr,
    output logic [(1<<OFS_W)*DATA_W-1:0]     slot_data,
    output logic [(1<<OFS_W)-1:0]            slot_full
);
    localparam int PAGE_BYTES = 1 << OFS_W;

    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] dat;
        logic [PAGE_BYTES-1:0]             full;
    } pg_t;

    pg_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.full = '0;
        end else if (wr_en) begin
            d.dat[wr_idx]  = wr_data;
            d.full[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        assign slot_data[g*DATA_W +: DATA_W] = q.dat[g];
    end
    assign slot_full = q.full;
endmodule

// File: rtl/eepr_ctrl_emu.sv
module eepr_ctrl_emu #(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int OFS_W        = 4,
    parameter int MIN_LOW_CYC  = 3,
    parameter int LOAD_WIN_CYC = 5000,
    parameter int PROG_CYC     = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    import eepr_pkg::*;

    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int PG_W       = ADDR_W - OFS_W;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int WIN_W      = $clog2(LOAD_WIN_CYC + 1);
    localparam int PRG_W      = $clog2(PROG_CYC + 1);

    typedef struct packed {
        ph_e               st;
        logic [PG_W-1:0]   page;
        logic [ADDR_W-1:0] la;
        logic [DATA_W-1:0] ldat;
        logic [WIN_W-1:0]  win;
        logic [PRG_W-1:0]  prg;
    } ctl_t;

    ctl_t q, d;

    logic [2:0]               strb_s;
    logic [ADDR_W-1:0]        addr_s;
    logic [DATA_W-1:0]        data_s;
    logic                     rd_act, wr_act, ld_start, ld_valid;
    logic [ADDR_W-1:0]        ld_addr;
    logic [DATA_W-1:0]        ld_data;
    logic                     buf_wr, buf_clr, arr_commit;
    logic [PAGE_BYTES*DATA_W-1:0] slot_data;
    logic [PAGE_BYTES-1:0]    slot_full;
    logic [DATA_W-1:0]        mem_q [DEPTH];
    logic [DATA_W-1:0]        rd_word;

    eepr_sync #(.W(3), .INIT(3'b111)) u_strb_sync (
        .clk(clk), .rst_n(rst_n),
        .din({ce_n, oe_n, we_n}), .dout(strb_s)
    );

    eepr_sync #(.W(ADDR_W + DATA_W), .INIT('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n),
        .din({addr, data_in}), .dout({addr_s, data_s})
    );

    eepr_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_LOW_CYC(MIN_LOW_CYC)) u_cycle (
        .clk(clk), .rst_n(rst_n),
        .ce_s(strb_s[2]), .oe_s(strb_s[1]), .we_s(strb_s[0]),
        .addr_s(addr_s), .data_s(data_s),
        .rd_act(rd_act), .wr_act(wr_act), .ld_start(ld_start),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    eepr_page #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_page (
        .clk(clk), .rst_n(rst_n),
        .wr_en(buf_wr), .wr_idx(ld_addr[OFS_W-1:0]), .wr_data(ld_data),
        .clr(buf_clr), .slot_data(slot_data), .slot_full(slot_full)
    );

    always_comb begin
        d          = q;
        buf_wr     = 1'b0;
        buf_clr    = 1'b0;
        arr_commit = 1'b0;
        if (ld_start) begin
            d.win = '0;
        end else if (q.win < WIN_W'(LOAD_WIN_CYC)) begin
            d.win = q.win + WIN_W'(1);
        end
        case (q.st)
            ST_IDLE: begin
                if (ld_valid) begin
                    buf_wr = 1'b1;
                    d.page = ld_addr[ADDR_W-1:OFS_W];
                    d.la   = ld_addr;
                    d.ldat = ld_data;
                    d.st   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (ld_valid) begin
                    if (ld_addr[ADDR_W-1:OFS_W] == q.page) begin
                        buf_wr = 1'b1;
                        d.la   = ld_addr;
                        d.ldat = ld_data;
                    end
                end else if (!wr_act && (q.win >= WIN_W'(LOAD_WIN_CYC))) begin
                    d.st  = ST_PROG;
                    d.prg = '0;
                end
            end
            ST_PROG: begin
                if (q.prg == PRG_W'(PROG_CYC - 1)) begin
                    arr_commit = 1'b1;
                    buf_clr    = 1'b1;
                    d.st       = ST_IDLE;
                end else begin
                    d.prg = q.prg + PRG_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (arr_commit) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (slot_full[j]) begin
                    mem_q[{q.page, OFS_W'(j)}] <= slot_data[j*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_comb begin
        rd_word = mem_q[addr_s];
        if ((q.st == ST_PROG) && (addr_s == q.la)) begin
            rd_word = {~q.ldat[DATA_W-1], q.ldat[DATA_W-2:0]};
        end
        data_oe  = rd_act;
        data_out = rd_act ? rd_word : '0;
    end

    // R1: the bus is driven only if the pins asked for a read two cycles back
    assert_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!$past(ce_n, 2) && !$past(oe_n, 2) && $past(we_n, 2)));

    // R9: the open page keeps its address for as long as loading continues
    assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOAD && $past(q.st) == ST_LOAD) |-> $stable(q.page));

    // R10: the buffer is frozen while programming runs
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PROG) |=> ($stable(slot_full) || q.st == ST_IDLE));

    // R6: the busy counter never passes its limit
    assert_prog_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PROG) |-> (q.prg < PRG_W'(PROG_CYC)));

    // R11: no byte waits in the buffer unless a page is open or programming
    assert_idle_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> (slot_full == '0));
endmodule

// File: tb/sim_eepr_ctrl_emu.sv
`timescale 1ns/1ps
module sim_eepr_ctrl_emu;
    localparam int WIN  = 40;
    localparam int PRG  = 300;
    localparam int HOLD = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [7:0] model [2048];

    always #2 clk = ~clk;

    eepr_ctrl_emu #(.LOAD_WIN_CYC(WIN), .PROG_CYC(PRG)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
    );

    function automatic logic [7:0] poll_val(input logic [7:0] v);
        return {~v[7], v[6:0]};
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; data_in = v; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        idle(HOLD);
        ce_n = 1'b1; we_n = 1'b1;
        idle(2);
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] v, output logic o);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        idle(4);
        v = data_out; o = data_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        idle(3);
    endtask

    task automatic settle();
        idle(WIN + PRG + 80);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired got=%h exp=%h", 8'h00, 8'h01);
        finish_run();
    end

    initial begin
        logic [7:0]  v;
        logic        o;
        logic [10:0] pa;
        logic [7:0]  pend_d [16];
        bit          pend_v [16];
        logic [10:0] last_a;
        logic [7:0]  last_d;
        int          n;

        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) model[i] = 8'hFF;

        idle(5);
        rst_n = 1'b1;
        idle(3);

        // R1 / R11: reset state
        chk("R1 idle bus released", {7'd0, data_oe}, 8'h00);
        chk("R1 idle data zero", data_out, 8'h00);
        rd(11'h005, v, o);
        chk("R11 reset array value", v, 8'hFF);
        chk("R1 read drives bus", {7'd0, o}, 8'h01);

        // R1: chip selected, read strobe high -> released
        @(negedge clk);
        addr = 11'h005; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        idle(4);
        chk("R1 oe high released", {7'd0, data_oe}, 8'h00);
        ce_n = 1'b1;
        idle(3);

        // R3: chip-select-controlled write, address and data moved mid-strobe
        @(negedge clk);
        addr = 11'h123; data_in = 8'h11; we_n = 1'b0;
        idle(3);
        addr = 11'h240; ce_n = 1'b0;
        idle(2);
        addr = 11'h3F7; data_in = 8'h22;
        idle(2);
        data_in = 8'h5A;
        idle(3);
        ce_n = 1'b1; data_in = 8'h99;
        idle(1);
        we_n = 1'b1;
        settle();
        model[11'h240] = 8'h5A;
        rd(11'h240, v, o);
        chk("R3 late fall address, first rise data", v, 8'h5A);
        rd(11'h123, v, o);
        chk("R3 early address untouched", v, 8'hFF);
        rd(11'h3F7, v, o);
        chk("R3 mid-strobe address untouched", v, 8'hFF);

        // R8: one-cycle glitch loads nothing
        @(negedge clk);
        addr = 11'h300; data_in = 8'h00; ce_n = 1'b0; we_n = 1'b0;
        idle(1);
        ce_n = 1'b1; we_n = 1'b1;
        settle();
        rd(11'h300, v, o);
        chk("R8 short pulse ignored", v, 8'hFF);

        // R2: strobe with oe low loads nothing
        @(negedge clk);
        addr = 11'h301; data_in = 8'h00; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        idle(HOLD);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        settle();
        rd(11'h301, v, o);
        chk("R2 oe low blocks write", v, 8'hFF);

        // R5 / R10: a load after the window closes is dropped
        wr(11'h411, 8'h3C);
        idle(100);
        wr(11'h412, 8'hC3);
        settle();
        model[11'h411] = 8'h3C;
        rd(11'h411, v, o);
        chk("R5 first byte programmed", v, 8'h3C);
        rd(11'h412, v, o);
        chk("R10 load during programming ignored", v, 8'hFF);

        // R5 / R6 / R7 / R10: two loads inside the window, polled while busy
        wr(11'h423, 8'h81);
        idle(25);
        wr(11'h424, 8'h42);
        idle(50);
        rd(11'h424, v, o);
        chk("R7 poll inverts bit 7", v, poll_val(8'h42));
        rd(11'h423, v, o);
        chk("R10 other address reads array while busy", v, 8'hFF);
        chk("R6 array not yet written", v, model[11'h423]);
        settle();
        model[11'h423] = 8'h81; model[11'h424] = 8'h42;
        rd(11'h424, v, o);
        chk("R7 true data after programming", v, 8'h42);
        rd(11'h423, v, o);
        chk("R5 both bytes in one cycle", v, 8'h81);

        // R4 / R9 / R11: random pages with stray foreign-page loads
        for (int it = 0; it < 8; it++) begin
            pa = {7'($urandom % 128), 4'd0};
            if (pa[10:4] == 7'h41 || pa[10:4] == 7'h42) pa[10:4] = 7'h10 + 7'(it);
            for (int k = 0; k < 16; k++) pend_v[k] = 1'b0;
            n = 1 + int'($urandom % 16);
            last_a = pa; last_d = 8'h00;
            for (int k = 0; k < n; k++) begin
                logic [3:0] ofs;
                logic [7:0] dv;
                ofs = 4'($urandom % 16);
                dv  = 8'($urandom);
                wr({pa[10:4], ofs}, dv);
                pend_d[ofs] = dv; pend_v[ofs] = 1'b1;
                last_a = {pa[10:4], ofs}; last_d = dv;
                if (k < n - 1 && ($urandom % 4) == 0) begin
                    wr({pa[10:4] ^ 7'h01, ofs}, ~dv);
                end
            end
            idle(50);
            rd(last_a, v, o);
            chk("R7 random poll", v, poll_val(last_d));
            settle();
            for (int k = 0; k < 16; k++) begin
                if (pend_v[k]) model[{pa[10:4], 4'(k)}] = pend_d[k];
            end
            for (int k = 0; k < 16; k++) begin
                rd({pa[10:4], 4'(k)}, v, o);
                chk("R4 R11 random page byte", v, model[{pa[10:4], 4'(k)}]);
            end
            rd({pa[10:4] ^ 7'h01, 4'(it)}, v, o);
            chk("R9 foreign page untouched", v, model[{pa[10:4] ^ 7'h01, 4'(it)}]);
        end

        finish_run();
    end
endmodule